// File: doc/BRIEF.md
# Prioritized Interrupt Controller Registers

This block sits between 32 peripheral interrupt lines and a processor core. It keeps three pieces of state: an enable mask, a pending mask and a 2-bit priority for each line. Software reaches all three through a 32-bit register port with byte-lane write strobes. Enable and pending each have two addresses: writing one sets the marked bits, writing the other clears them, and reading either returns the mask. Hardware sources can also set pending bits with one-cycle pulses.

A line is a candidate when it is both pending and enabled. The block always picks one winner: the lowest priority value wins first, and the lowest line number breaks ties. It offers the winner to the core as exception number 16 plus the line number, together with a valid flag. A small offer state machine drives the valid flag. In `ST_IDLE` nothing is offered. `ST_IDLE` moves to `ST_OFFER` (transition *arm*) when a candidate exists. In `ST_OFFER` the current winner is shown. `ST_OFFER` moves back to `ST_IDLE` (transition *drain*) when the candidates are gone, and to `ST_HOLD` (transition *take*) when the core strobes `take`. `ST_HOLD` blanks the offer for one cycle, so a line that was just taken is never shown again. From `ST_HOLD` the machine goes to `ST_OFFER` (transition *rearm*) if a candidate is left, or to `ST_IDLE` (transition *rest*) if not.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every line has priority 0, the enable and pending masks read as zero, and `irq_valid` is low.
- R2: A write to offset 0x100 ORs the strobed data into the enable mask. A write to 0x180 clears each enable bit where the strobed data is one. Reading 0x100 or 0x180 returns the enable mask, with bit n for line n.
- R3: Offsets 0x200 (set) and 0x280 (clear) act the same way on the pending mask. Reading either of them returns the pending mask.
- R4: Priority word k sits at offset 0x400+4k, for k from 0 to 7. Line n uses bits [7:6] of byte n mod 4 in word n div 4. A read returns each line's 2-bit priority in those bits and zero in all other bits. For example, priorities 1, 2, 3, 3 on lines 20..23 read back from 0x414 as 0xC0C08040.
- R5: Byte strobe bit b gates data bits [8b+7:8b] on every register. A lane whose strobe is low changes nothing.
- R6: The winner is the candidate (pending AND enabled) with the lowest priority value. Among candidates with equal priority, the lowest line number wins.
- R7: While `irq_valid` is high, `irq_num` equals 16 plus the winning line number.
- R8: The outputs are registered. After a change to the masks or priorities at clock edge E, the outputs still show the old winner after E and show the new one after E+1.
- R9: When `take` is high while a line is offered, that line's pending bit clears at that edge and `irq_valid` is low for the next cycle. A `take` while nothing is offered is ignored.
- R10: If a set from `hw_set` or from a set-pending write arrives in the same cycle as a clear of the same bit (by `take` or a clear write), the set wins.
- R11: A one-cycle pulse on `hw_set[n]` sets pending bit n.
- R12: Offsets outside the ranges above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wstrb | input | 4 | Byte-lane enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_set | input | 32 | Hardware set-pending pulses, one per line |
| take | input | 1 | Core accepts the offered exception |
| irq_valid | output | 1 | An exception is offered |
| irq_num | output | 6 | Offered exception number (16 + line) |

## Verification
Several writers can touch the pending mask in the same cycle. The core's `take` clears the offered line, while `hw_set` or a set-pending write can set that same line. The bench provokes this collision in two ways. Directed cycles pair `take` with a hardware pulse and with a software set on the offered line. Random cycles issue take, pulses and register writes together. The outcome is judged from the ports: the pending mask read back, the blanked `irq_valid` in the cycle after the take, and which line is offered once the hold cycle is over.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Word indices (byte offset >> 2) of the register windows
    localparam logic [9:0] WA_EN_SET = 10'h040;
    localparam logic [9:0] WA_EN_CLR = 10'h060;
    localparam logic [9:0] WA_PD_SET = 10'h080;
    localparam logic [9:0] WA_PD_CLR = 10'h0A0;
    localparam logic [9:0] WA_PRIO   = 10'h100;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HOLD  = 2'd2
    } offer_state_t;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [11:0]                    bus_addr,
    input  logic                           bus_wr,
    input  logic [3:0]                     bus_wstrb,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_LINES-1:0]           hw_set,
    input  logic [NUM_LINES-1:0]           take_clr,
    output logic [NUM_LINES-1:0]           en_q,
    output logic [NUM_LINES-1:0]           pend_q,
    output logic [NUM_LINES*PRIO_BITS-1:0] prio_flat
);

    localparam int PRIO_WORDS = (NUM_LINES + LANES - 1) / LANES;
    localparam int PRIO_LSB   = 8 - PRIO_BITS;

    logic [9:0]           word_a;
    logic [9:0]           prio_idx;
    logic                 prio_sel;
    logic [31:0]          lane_mask;
    logic [31:0]          wmasked;
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;

    assign word_a   = bus_addr[11:2];
    assign prio_idx = word_a - WA_PRIO;
    assign prio_sel = (word_a >= WA_PRIO) && (word_a < WA_PRIO + 10'(PRIO_WORDS));

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{bus_wstrb[b]}};
    end

    assign wmasked = bus_wdata & lane_mask;
    assign wbits   = wmasked[NUM_LINES-1:0];

    assign en_set = (bus_wr && word_a == WA_EN_SET) ? wbits : '0;
    assign en_clr = (bus_wr && word_a == WA_EN_CLR) ? wbits : '0;
    assign pd_set = (bus_wr && word_a == WA_PD_SET) ? wbits : '0;
    assign pd_clr = (bus_wr && word_a == WA_PD_CLR) ? wbits : '0;

    // Sets are applied after clears so a same-cycle set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= (en_q & ~en_clr) | en_set;
            pend_q <= (pend_q & ~(pd_clr | take_clr)) | pd_set | hw_set;
        end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_prio
        localparam int WI = n / LANES;
        localparam int BI = n % LANES;
        logic                 hit;
        logic [PRIO_BITS-1:0] val;

        assign hit = bus_wr && prio_sel && (prio_idx == 10'(WI)) && bus_wstrb[BI];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val <= '0;
            end else if (hit) begin
                val <= bus_wdata[8*BI+PRIO_LSB +: PRIO_BITS];
            end
        end

        assign prio_flat[n*PRIO_BITS +: PRIO_BITS] = val;
    end

    always_comb begin
        bus_rdata = '0;
        if (word_a == WA_EN_SET || word_a == WA_EN_CLR) begin
            bus_rdata[NUM_LINES-1:0] = en_q;
        end else if (word_a == WA_PD_SET || word_a == WA_PD_CLR) begin
            bus_rdata[NUM_LINES-1:0] = pend_q;
        end else if (prio_sel) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (n / LANES == int'(prio_idx)) begin
                    bus_rdata[8*(n%LANES)+PRIO_LSB +: PRIO_BITS] = prio_flat[n*PRIO_BITS +: PRIO_BITS];
                end
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]           en,
    input  logic [NUM_LINES-1:0]           pend,
    input  logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
    output logic [NUM_LINES-1:0]           cand,
    output logic                           any,
    output logic [LINE_W-1:0]              win_line
);

    localparam int NUM_LEVELS = 1 << PRIO_BITS;

    logic [NUM_LINES-1:0] lvl_mask [NUM_LEVELS];

    assign cand = pend & en;
    assign any  = |cand;

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
            assign lvl_mask[l][n] = cand[n] && (prio_flat[n*PRIO_BITS +: PRIO_BITS] == PRIO_BITS'(l));
        end
    end

    // Descending sweeps: the last assignment made is the lowest level, lowest line
    always_comb begin
        win_line = '0;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (|lvl_mask[l]) begin
                for (int i = NUM_LINES - 1; i >= 0; i--) begin
                    if (lvl_mask[l][i]) begin
                        win_line = LINE_W'(i);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 2,
    parameter int EXC_BASE  = 16,
    parameter int LINE_W    = $clog2(NUM_LINES),
    parameter int EXC_W     = $clog2(EXC_BASE + NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic [3:0]           bus_wstrb,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] hw_set,
    input  logic                 take,
    output logic                 irq_valid,
    output logic [EXC_W-1:0]     irq_num
);

    logic [NUM_LINES-1:0]           en_q, pend_q, cand;
    logic [NUM_LINES*PRIO_BITS-1:0] prio_flat;
    logic [NUM_LINES-1:0]           take_clr;
    logic                           any;
    logic [LINE_W-1:0]              win_line;
    logic [LINE_W-1:0]              line_q;
    offer_state_t                   state_q, state_d;

    irq_regfile #(
        .NUM_LINES(NUM_LINES),
        .PRIO_BITS(PRIO_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wstrb(bus_wstrb),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hw_set   (hw_set),
        .take_clr (take_clr),
        .en_q     (en_q),
        .pend_q   (pend_q),
        .prio_flat(prio_flat)
    );

    irq_arbiter #(
        .NUM_LINES(NUM_LINES),
        .PRIO_BITS(PRIO_BITS),
        .LINE_W   (LINE_W)
    ) u_arb (
        .en       (en_q),
        .pend     (pend_q),
        .prio_flat(prio_flat),
        .cand     (cand),
        .any      (any),
        .win_line (win_line)
    );

    assign take_clr = (state_q == ST_OFFER && take) ? (NUM_LINES'(1) << line_q) : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = any ? ST_OFFER : ST_IDLE;                      // arm
            ST_OFFER: state_d = take ? ST_HOLD : (any ? ST_OFFER : ST_IDLE);   // take / drain
            ST_HOLD:  state_d = any ? ST_OFFER : ST_IDLE;                      // rearm / rest
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= win_line;
        end
    end

    always_comb begin
        irq_valid = (state_q == ST_OFFER);
        irq_num   = EXC_W'(EXC_BASE) + EXC_W'(line_q);
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int NUM_LINES = 32,
    parameter int EXC_BASE  = 16,
    parameter int EXC_W     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 take,
    input logic                 irq_valid,
    input logic [EXC_W-1:0]     irq_num,
    input logic [NUM_LINES-1:0] hw_set,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] cand
);

    // R7
    exc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_num) >= EXC_BASE && int'(irq_num) < EXC_BASE + NUM_LINES));

    // R9
    take_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && take) |=> !irq_valid);

    // R10
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((pend & $past(hw_set)) == $past(hw_set)));

    // R6
    valid_has_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(cand) != '0));

endmodule

bind irq_ctrl irq_ctrl_chk #(
    .NUM_LINES(NUM_LINES),
    .EXC_BASE (EXC_BASE),
    .EXC_W    (EXC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .irq_valid(irq_valid),
    .irq_num  (irq_num),
    .hw_set   (hw_set),
    .pend     (pend_q),
    .cand     (cand)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_set = '0;
    logic        take = 1'b0;
    logic        irq_valid;
    logic [5:0]  irq_num;

    int checks = 0;
    int errs = 0;

    // Bench model of the block state
    logic [31:0] en_m = '0;
    logic [31:0] pend_m = '0;
    logic [1:0]  prio_m [32];
    bit          exp_valid = 1'b0;
    int          exp_line = 0;

    irq_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wstrb(bus_wstrb),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hw_set   (hw_set),
        .take     (take),
        .irq_valid(irq_valid),
        .irq_num  (irq_num)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r;
        int w;
        r = '0;
        w = int'(a[11:2]);
        if (w == 'h40 || w == 'h60) r = en_m;
        else if (w == 'h80 || w == 'hA0) r = pend_m;
        else if (w >= 'h100 && w < 'h108) begin
            for (int b = 0; b < 4; b++) r[8*b+6 +: 2] = prio_m[(w - 'h100)*4 + b];
        end
        return r;
    endfunction

    function automatic int exp_win();
        logic [31:0] c;
        c = en_m & pend_m;
        for (int l = 0; l < 4; l++)
            for (int n = 0; n < 32; n++)
                if (c[n] && prio_m[n] == 2'(l)) return n;
        return -1;
    endfunction

    task automatic rd_chk(input logic [11:0] a, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp_read(a), req, bus_rdata, exp_read(a));
    endtask

    task automatic out_chk(input string req);
        if (exp_valid)
            chk(irq_valid && irq_num == 6'(16 + exp_line), req, {25'd0, irq_valid, irq_num}, {25'd1, 1'b1, 6'(16 + exp_line)});
        else
            chk(!irq_valid, req, {31'd0, irq_valid}, 32'd0);
    endtask

    // One stimulus cycle, then one settle cycle; called at a falling edge
    task automatic cyc(input bit wr, input logic [11:0] a, input logic [3:0] s, input logic [31:0] d,
                       input logic [31:0] hw, input bit tk, input string req);
        bit          took;
        logic [31:0] m, dm, eclr, eset, pclr, pset;
        int          w, r;
        took = tk && exp_valid;
        bus_wr = wr; bus_addr = a; bus_wstrb = s; bus_wdata = d; hw_set = hw; take = tk;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{s[b]}};
        dm = d & m;
        w = int'(a[11:2]);
        eclr = '0; eset = '0; pclr = '0; pset = hw;
        if (wr && w == 'h40) eset = dm;
        if (wr && w == 'h60) eclr = dm;
        if (wr && w == 'h80) pset = pset | dm;
        if (wr && w == 'hA0) pclr = dm;
        if (took) pclr = pclr | (32'd1 << exp_line);
        if (wr && w >= 'h100 && w < 'h108)
            for (int b = 0; b < 4; b++) if (s[b]) prio_m[(w - 'h100)*4 + b] = d[8*b+6 +: 2];
        en_m   = (en_m & ~eclr) | eset;
        pend_m = (pend_m & ~pclr) | pset;
        @(negedge clk);
        bus_wr = 1'b0; hw_set = '0; take = 1'b0;
        if (took) chk(!irq_valid, "R9 blank after take", {31'd0, irq_valid}, 32'd0);
        else out_chk("R8 old winner held");
        @(negedge clk);
        r = exp_win();
        exp_valid = (r >= 0);
        exp_line = (r >= 0) ? r : 0;
        out_chk(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [3:0]  s;
        logic [31:0] d, hw;
        int          op;
        for (int n = 0; n < 32; n++) prio_m[n] = 2'd0;
        void'($urandom(32'd20211));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!irq_valid, "R1 valid", {31'd0, irq_valid}, 32'd0);
        rd_chk(12'h100, "R1 enable");
        rd_chk(12'h200, "R1 pending");
        for (int k = 0; k < 8; k++) rd_chk(12'h400 + 12'(4*k), "R1 priority");

        // R4 priority packing
        cyc(1, 12'h414, 4'hF, 32'hC0C08040, 0, 0, "R4 settle");
        rd_chk(12'h414, "R4");
        chk(bus_rdata == 32'hC0C08040, "R4 literal", bus_rdata, 32'hC0C08040);
        cyc(1, 12'h400, 4'hF, 32'hFFFFFFFF, 0, 0, "R4 settle");
        rd_chk(12'h400, "R4");
        chk(bus_rdata == 32'hC0C0C0C0, "R4 only top bits", bus_rdata, 32'hC0C0C0C0);

        // R5 byte strobes
        cyc(1, 12'h414, 4'h1, 32'h00000000, 0, 0, "R5 settle");
        rd_chk(12'h414, "R5");
        chk(bus_rdata == 32'hC0C08000, "R5 priority lane", bus_rdata, 32'hC0C08000);
        cyc(1, 12'h100, 4'h2, 32'hFFFFFFFF, 0, 0, "R5 settle");
        rd_chk(12'h180, "R2");
        chk(bus_rdata == 32'h0000FF00, "R5 enable lane", bus_rdata, 32'h0000FF00);

        // R2 clear-enable
        cyc(1, 12'h180, 4'hF, 32'h00000100, 0, 0, "R2 settle");
        rd_chk(12'h100, "R2");
        chk(bus_rdata == 32'h0000FE00, "R2 clear", bus_rdata, 32'h0000FE00);

        // R12 unmapped
        cyc(1, 12'h300, 4'hF, 32'hFFFFFFFF, 0, 0, "R12 settle");
        bus_addr = 12'h300; #1;
        chk(bus_rdata == 32'd0, "R12 unmapped read", bus_rdata, 32'd0);
        rd_chk(12'h420, "R12");
        rd_chk(12'h100, "R12 enable untouched");
        rd_chk(12'h200, "R12 pending untouched");

        // R3, R6, R7, R8: lines 9, 11, 13 pending at priority 0
        cyc(1, 12'h200, 4'hF, 32'h00002A00, 0, 0, "R8 new winner");
        rd_chk(12'h280, "R3");
        chk(irq_valid && irq_num == 6'd25, "R7 exc number", {26'd0, irq_num}, 32'd25);
        cyc(1, 12'h408, 4'hF, 32'h0000C000, 0, 0, "R6");
        chk(irq_valid && irq_num == 6'd27, "R6 priority over line", {26'd0, irq_num}, 32'd27);

        // R9 take
        cyc(0, 12'h0, 4'h0, 0, 0, 1, "R9 next winner");
        chk(irq_num == 6'd29, "R9 line 11 cleared", {26'd0, irq_num}, 32'd29);
        // R10 set wins over take
        cyc(0, 12'h0, 4'h0, 0, 32'h00002000, 1, "R10 hw set");
        chk(irq_valid && irq_num == 6'd29, "R10 hw set kept line", {26'd0, irq_num}, 32'd29);
        cyc(1, 12'h200, 4'hF, 32'h00002000, 0, 1, "R10 sw set");
        chk(irq_valid && irq_num == 6'd29, "R10 sw set kept line", {26'd0, irq_num}, 32'd29);
        // R11 hardware pulse on a disabled line
        cyc(0, 12'h0, 4'h0, 0, 32'h00000002, 0, "R11");
        rd_chk(12'h200, "R11");
        chk(bus_rdata[1], "R11 pulse sets pending", bus_rdata, exp_read(12'h200));
        // R3 clear all pending
        cyc(1, 12'h280, 4'hF, 32'hFFFFFFFF, 0, 0, "R3 clear all");
        rd_chk(12'h200, "R3");
        // R9 take while idle ignored
        cyc(0, 12'h0, 4'h0, 0, 0, 1, "R9 idle take");

        // Random mix of writes, pulses and takes
        for (int it = 0; it < 500; it++) begin
            op = int'($urandom % 16);
            case (op)
                0, 1, 2, 3: a = 12'h100 + 12'(op * 'h80);
                4, 5, 6, 7, 8, 9, 10, 11: a = 12'h400 + 12'(4 * (op - 4));
                12: a = 12'h300;
                13: a = 12'h420;
                14: a = 12'h0FC;
                default: a = 12'h500;
            endcase
            s = ($urandom % 2) ? 4'hF : 4'($urandom);
            d = (op < 4) ? ($urandom & $urandom & $urandom) : $urandom;
            hw = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom & $urandom) : '0;
            cyc($urandom % 4 != 0, a, s, d, hw, $urandom % 3 == 0, "R6 R10 random");
            op = int'($urandom % 16);
            case (op)
                0, 1, 2, 3: a = 12'h100 + 12'(op * 'h80);
                4, 5, 6, 7, 8, 9, 10, 11: a = 12'h400 + 12'(4 * (op - 4));
                default: a = 12'h3F0;
            endcase
            rd_chk(a, "R2 R3 R4 readback");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule